// File: doc/BRIEF.md
# Charge Safety Timer with Thermal Rate Scaling

This block times the two charging phases of a single-cell battery charger: a short conditioning (precharge) phase and a longer fast-charge phase. A base tick from an external oscillator drives one shared timeout counter. The counter's limit is the programmed fast-charge timeout, or one tenth of it in precharge. A controller supplies a three-way mode: standby clears the timer, suspend freezes it, and charge lets it run. It also supplies the phase, a timer-disable input and the battery thresholds.

The charge current can be cut back by junction-temperature regulation. While that happens, the timer stretches its clock by the ratio of programmed current to actual current. This ratio is given as an unsigned Q4.4 code. Each base tick adds 1.0 to a fractional accumulator. When the accumulator reaches the ratio, that amount is taken off and the timeout counter advances by one. The correction therefore follows the current in real time.

A timeout sets a latched fault, which stops the charger. While the fault is held and input power is present, the block requests a small recovery current until the output climbs past the threshold that belongs to the faulted phase. Four events clear the latch: a rising charge enable, an input overvoltage, loss of input power, or the timer function being disabled.

Top module: `chg_safety_timer`

## Requirements
- R1: The fast-charge timeout is `fchg_limit` counter advances. The precharge timeout is floor(`fchg_limit`/10) advances. Both limits are never less than 1.
- R2: While `mode` is 0 or 3 (standby) or `timer_dis` is 1, the count and the accumulator stay at zero, and no tick counts toward a timeout.
- R3: While `mode` is 1 (suspend), ticks are ignored and the count and accumulator are kept. When `mode` returns to 2 (charge), timing resumes from the kept count.
- R4: In `mode` 2 with `therm_reg` low, every tick advances the count by one, whatever the value of `ratio_q`.
- R5: In `mode` 2 with `therm_reg` high, a tick advances the count only when the accumulator plus 16 (1.0 in Q4.4) is at least `ratio_q`. The ratio is then subtracted. A ratio below 16 is treated as 16, so a ratio of 32 halves the rate and 24 gives two advances per three ticks.
- R6: In precharge (`phase_fast`=0), the count runs only while `below_lowv` is 1. With `below_lowv` at 0 the count is cleared and no fault can arise.
- R7: A change of `phase_fast` clears the count and accumulator, so fast charge times from zero.
- R8: An expiring precharge count, or an expiring fast count while `terminated` is 0, sets `fault` on the next clock. While `terminated` is 1 in fast charge, the count is cleared.
- R9: `fault` clears on the clock after any of these: a 0-to-1 edge of `chg_en`, `ovp` high, `input_ok` low, or `timer_dis` high. A clear wins over a set, and a steady low `chg_en` does not clear.
- R10: `recov_en` is 1 exactly when `fault` is 1, `input_ok` is 1 and the output is below the faulted phase's threshold: `below_lowv` for a precharge fault, `below_rch` for a fast fault.
- R11: After reset, `fault` and `recov_en` are 0 and the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Base timer tick, one cycle wide |
| mode | input | 2 | 0/3 standby, 1 suspend, 2 charge |
| phase_fast | input | 1 | 0 precharge, 1 fast charge |
| timer_dis | input | 1 | Timer function disabled (regulator-only operation) |
| therm_reg | input | 1 | Thermal current regulation active |
| ratio_q | input | 8 | Programmed/actual current, unsigned Q4.4 |
| fchg_limit | input | CNT_W | Fast-charge timeout in counter advances |
| below_lowv | input | 1 | Battery/output below precharge threshold |
| below_rch | input | 1 | Output below recharge level |
| terminated | input | 1 | Charge termination reached |
| chg_en | input | 1 | Charge enable, active high |
| ovp | input | 1 | Input overvoltage detected |
| input_ok | input | 1 | Input power detected |
| fault | output | 1 | Latched safety-timer fault |
| recov_en | output | 1 | Fault recovery current enable |

## Verification
The assertions assume that `tick` is a single-cycle pulse, that `mode` moves between standby, suspend and charge only at clock edges, and that `fchg_limit` and `ratio_q` change only while the timer is cleared. The stimulus meets these assumptions. It drives every input on the falling edge, raises `tick` for exactly one cycle with an idle cycle after it, and loads a new ratio or limit only after a `timer_dis` pulse has cleared the counter. Outputs are sampled on the falling edge after the clock that consumed the last tick.

// File: rtl/chg_tmr_pkg.sv
`timescale 1ns/1ps
package chg_tmr_pkg;
  localparam int RATIO_W = 8;
  localparam int FRAC_W  = 4;
  localparam logic [RATIO_W-1:0] RATIO_ONE = RATIO_W'(1 << FRAC_W);

  localparam logic [1:0] M_STANDBY = 2'd0;
  localparam logic [1:0] M_HOLD    = 2'd1;
  localparam logic [1:0] M_COUNT   = 2'd2;

  // Effective slowdown ratio: 1.0 outside thermal regulation, clamped to >= 1.0
  function automatic logic [RATIO_W-1:0] eff_ratio(input logic therm,
                                                   input logic [RATIO_W-1:0] r);
    logic [RATIO_W-1:0] v;
    if (!therm)              v = RATIO_ONE;
    else if (r < RATIO_ONE)  v = RATIO_ONE;
    else                     v = r;
    return v;
  endfunction

  // One accumulator step: adds 1.0, returns carry and new value
  function automatic logic [RATIO_W+1:0] acc_step(input logic [RATIO_W:0] acc,
                                                  input logic [RATIO_W-1:0] r);
    logic [RATIO_W:0] sum;
    logic             carry;
    sum   = acc + {1'b0, RATIO_ONE};
    carry = (sum >= {1'b0, r});
    if (carry) sum = sum - {1'b0, r};
    return {carry, sum};
  endfunction
endpackage

// File: rtl/tmr_rate_acc.sv
`timescale 1ns/1ps
module tmr_rate_acc
  import chg_tmr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               run,
  input  logic [RATIO_W-1:0] ratio_eff,
  output logic               advance
);
  logic [RATIO_W:0]   acc_q;
  logic [RATIO_W+1:0] step;

  always_comb begin
    step    = acc_step(acc_q, ratio_eff);
    advance = run && step[RATIO_W+1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (clr)    acc_q <= '0;
    else if (run)    acc_q <= step[RATIO_W:0];
  end
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
  parameter int CNT_W = 24,
  parameter int PRE_DIV = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             advance,
  input  logic             phase_fast,
  input  logic [CNT_W-1:0] fchg_limit,
  output logic             expire,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] limit_of(input logic fast,
                                                input logic [CNT_W-1:0] l);
    logic [CNT_W-1:0] v;
    v = fast ? l : l / CNT_W'(PRE_DIV);
    if (v == '0) v = ONE;
    return v;
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic [CNT_W:0]   nxt;

  always_comb begin
    lim    = limit_of(phase_fast, fchg_limit);
    nxt    = {1'b0, cnt_q} + {1'b0, ONE};
    expire = advance && (nxt >= {1'b0, lim});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clr)      cnt_q <= '0;
    else if (advance)  cnt_q <= nxt[CNT_W-1:0];
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tmr_fault_latch.sv
`timescale 1ns/1ps
module tmr_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic set_fast,
  input  logic chg_en,
  input  logic ovp,
  input  logic input_ok,
  input  logic timer_dis,
  input  logic below_lowv,
  input  logic below_rch,
  output logic clr_evt,
  output logic fault,
  output logic recov_en
);
  logic en_q, fault_q, kind_fast_q;

  always_comb begin
    clr_evt  = (chg_en && !en_q) || ovp || !input_ok || timer_dis;
    recov_en = fault_q && input_ok && (kind_fast_q ? below_rch : below_lowv);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q        <= 1'b0;
      fault_q     <= 1'b0;
      kind_fast_q <= 1'b0;
    end else begin
      en_q <= chg_en;
      if (clr_evt) begin
        fault_q <= 1'b0;
      end else if (set) begin
        fault_q     <= 1'b1;
        kind_fast_q <= set_fast;
      end
    end
  end

  assign fault = fault_q;
endmodule

// File: rtl/chg_safety_timer.sv
`timescale 1ns/1ps
module chg_safety_timer
  import chg_tmr_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [1:0]         mode,
  input  logic               phase_fast,
  input  logic               timer_dis,
  input  logic               therm_reg,
  input  logic [RATIO_W-1:0] ratio_q,
  input  logic [CNT_W-1:0]   fchg_limit,
  input  logic               below_lowv,
  input  logic               below_rch,
  input  logic               terminated,
  input  logic               chg_en,
  input  logic               ovp,
  input  logic               input_ok,
  output logic               fault,
  output logic               recov_en
);
  logic               phase_q;
  logic               w_cnt_clr;
  logic               w_run;
  logic               w_advance;
  logic               w_expire;
  logic               w_fault_clr;
  logic [CNT_W-1:0]   w_cnt;
  logic [RATIO_W-1:0] w_ratio;

  always_comb begin
    w_cnt_clr = (mode != M_HOLD && mode != M_COUNT) || timer_dis || fault
             || (phase_fast != phase_q)
             || (!phase_fast && !below_lowv)
             || (phase_fast && terminated);
    w_run     = tick && (mode == M_COUNT) && !w_cnt_clr;
    w_ratio   = eff_ratio(therm_reg, ratio_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_fast;
  end

  tmr_rate_acc u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (w_cnt_clr),
    .run       (w_run),
    .ratio_eff (w_ratio),
    .advance   (w_advance)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (w_cnt_clr),
    .advance    (w_advance),
    .phase_fast (phase_fast),
    .fchg_limit (fchg_limit),
    .expire     (w_expire),
    .cnt        (w_cnt)
  );

  tmr_fault_latch u_flt (
    .clk        (clk),
    .rst_n      (rst_n),
    .set        (w_expire),
    .set_fast   (phase_fast),
    .chg_en     (chg_en),
    .ovp        (ovp),
    .input_ok   (input_ok),
    .timer_dis  (timer_dis),
    .below_lowv (below_lowv),
    .below_rch  (below_rch),
    .clr_evt    (w_fault_clr),
    .fault      (fault),
    .recov_en   (recov_en)
  );
endmodule

// File: rtl/chg_safety_timer_chk.sv
`timescale 1ns/1ps
module chg_safety_timer_chk
  import chg_tmr_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [1:0]       mode,
  input logic             timer_dis,
  input logic             therm_reg,
  input logic             input_ok,
  input logic             fault,
  input logic             recov_en,
  input logic             w_cnt_clr,
  input logic             w_advance,
  input logic             w_expire,
  input logic             w_fault_clr,
  input logic [CNT_W-1:0] w_cnt
);
  // R2: standby or disabled leaves a zero count
  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_STANDBY) || timer_dis) |=> (w_cnt == '0));
  // R3: suspend keeps the count
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_HOLD) && !w_cnt_clr) |=> $stable(w_cnt));
  // R4: full rate outside thermal regulation
  a_r4_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (mode == M_COUNT) && !w_cnt_clr && !therm_reg) |-> w_advance);
  // R5: no advance without a tick
  a_r5_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |-> !w_advance);
  // R8: expiry latches the fault
  a_r8_fault_set: assert property (@(posedge clk) disable iff (!rst_n)
    (w_expire && !w_fault_clr) |=> fault);
  // R9: clear events drop the fault
  a_r9_fault_clr: assert property (@(posedge clk) disable iff (!rst_n)
    w_fault_clr |=> !fault);
  // R10: recovery current only with a held fault and input present
  a_r10_recov_gate: assert property (@(posedge clk) disable iff (!rst_n)
    recov_en |-> (fault && input_ok));
endmodule

bind chg_safety_timer chg_safety_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .mode        (mode),
  .timer_dis   (timer_dis),
  .therm_reg   (therm_reg),
  .input_ok    (input_ok),
  .fault       (fault),
  .recov_en    (recov_en),
  .w_cnt_clr   (w_cnt_clr),
  .w_advance   (w_advance),
  .w_expire    (w_expire),
  .w_fault_clr (w_fault_clr),
  .w_cnt       (w_cnt)
);

// File: tb/chg_safety_timer_tb.sv
`timescale 1ns/1ps
module chg_safety_timer_tb;
  localparam int CNT_W = 24;
  localparam int LIM   = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, phase_fast = 0, timer_dis = 0, therm_reg = 0;
  logic below_lowv = 1, below_rch = 1, terminated = 0;
  logic chg_en = 1, ovp = 0, input_ok = 1;
  logic [1:0] mode = 2'd0;
  logic [7:0] ratio_q = 8'd16;
  logic [CNT_W-1:0] fchg_limit = CNT_W'(LIM);
  logic fault, recov_en;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  chg_safety_timer #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .phase_fast(phase_fast),
    .timer_dis(timer_dis), .therm_reg(therm_reg), .ratio_q(ratio_q),
    .fchg_limit(fchg_limit), .below_lowv(below_lowv), .below_rch(below_rch),
    .terminated(terminated), .chg_en(chg_en), .ovp(ovp), .input_ok(input_ok),
    .fault(fault), .recov_en(recov_en));

  typedef struct packed {
    logic        fast;
    logic        therm;
    logic [7:0]  ratio;
    logic [15:0] ticks;
    logic        exp;
  } vec_t;

  // Expected ticks: R1 limits 40 / 4; R5 ratio 32 doubles, ratio 24 gives 2 per 3 ticks
  localparam vec_t VEC [14] = '{
    '{1'b1, 1'b0, 8'd16, 16'd39, 1'b0},  // R1 fast
    '{1'b1, 1'b0, 8'd16, 16'd40, 1'b1},  // R1 fast
    '{1'b0, 1'b0, 8'd16, 16'd3,  1'b0},  // R1 precharge
    '{1'b0, 1'b0, 8'd16, 16'd4,  1'b1},  // R1 precharge
    '{1'b1, 1'b0, 8'd32, 16'd40, 1'b1},  // R4 ratio ignored
    '{1'b1, 1'b1, 8'd32, 16'd79, 1'b0},  // R5 half rate
    '{1'b1, 1'b1, 8'd32, 16'd80, 1'b1},  // R5
    '{1'b1, 1'b1, 8'd24, 16'd59, 1'b0},  // R5 1.5x
    '{1'b1, 1'b1, 8'd24, 16'd60, 1'b1},  // R5
    '{1'b0, 1'b1, 8'd32, 16'd7,  1'b0},  // R5 precharge slowed
    '{1'b0, 1'b1, 8'd32, 16'd8,  1'b1},  // R5
    '{1'b1, 1'b1, 8'd8,  16'd39, 1'b0},  // R5 clamp to 1.0
    '{1'b1, 1'b1, 8'd8,  16'd40, 1'b1},  // R5
    '{1'b1, 1'b1, 8'd0,  16'd40, 1'b1}   // R5 zero ratio clamp
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; @(negedge clk);
    end
  endtask

  // Clears fault and count, then arms counting in the chosen phase
  task automatic arm(input logic fast, input logic th, input logic [7:0] r);
    timer_dis = 1'b1; mode = 2'd0; phase_fast = fast; therm_reg = th; ratio_q = r;
    below_lowv = 1'b1; terminated = 1'b0; ovp = 1'b0; input_ok = 1'b1; chg_en = 1'b1;
    cyc(2);
    timer_dis = 1'b0; mode = 2'd2;
    cyc(1);
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    check("R11 fault after reset", fault, 0);
    check("R11 recov after reset", recov_en, 0);
    rst_n = 1'b1;
    cyc(2);

    foreach (VEC[k]) begin
      arm(VEC[k].fast, VEC[k].therm, VEC[k].ratio);
      ticks(int'(VEC[k].ticks));
      check($sformatf("R1/R4/R5 vector %0d", k), fault, int'(VEC[k].exp));
    end

    // R2: standby clears progress
    arm(1'b1, 1'b0, 8'd16);
    ticks(30); mode = 2'd0; ticks(5); mode = 2'd2; cyc(1);
    ticks(39);
    check("R2 standby clears", fault, 0);
    ticks(1);
    check("R2 full limit after standby", fault, 1);

    // R3: suspend holds
    arm(1'b1, 1'b0, 8'd16);
    ticks(20); mode = 2'd1; ticks(30); mode = 2'd2; cyc(1);
    ticks(19);
    check("R3 hold no early fault", fault, 0);
    ticks(1);
    check("R3 resumes from held count", fault, 1);

    // R6: precharge with battery above threshold
    arm(1'b0, 1'b0, 8'd16);
    below_lowv = 1'b0;
    ticks(10);
    check("R6 no precharge fault above threshold", fault, 0);

    // R7: phase change restarts
    arm(1'b0, 1'b0, 8'd16);
    ticks(3); phase_fast = 1'b1; cyc(1);
    ticks(39);
    check("R7 fast from zero", fault, 0);
    ticks(1);
    check("R7 fast timeout", fault, 1);

    // R8: terminated fast charge never faults
    arm(1'b1, 1'b0, 8'd16);
    terminated = 1'b1;
    ticks(50);
    check("R8 no fault when terminated", fault, 0);

    // R10: recovery thresholds per phase
    arm(1'b0, 1'b0, 8'd16);
    ticks(4);
    below_lowv = 1'b1; below_rch = 1'b0; #1;
    check("R10 precharge recov on", recov_en, 1);
    below_lowv = 1'b0; below_rch = 1'b1; #1;
    check("R10 precharge recov off", recov_en, 0);
    arm(1'b1, 1'b0, 8'd16);
    ticks(40);
    below_rch = 1'b1; below_lowv = 1'b0; #1;
    check("R10 fast recov on", recov_en, 1);
    below_rch = 1'b0; below_lowv = 1'b1; #1;
    check("R10 fast recov off", recov_en, 0);
    below_rch = 1'b1;

    // R9: clear events
    arm(1'b1, 1'b0, 8'd16); ticks(40);
    chg_en = 1'b0; cyc(2);
    check("R9 low enable keeps fault", fault, 1);
    chg_en = 1'b1; cyc(1);
    check("R9 enable edge clears", fault, 0);
    arm(1'b1, 1'b0, 8'd16); ticks(40);
    ovp = 1'b1; cyc(1); ovp = 1'b0;
    check("R9 overvoltage clears", fault, 0);
    arm(1'b1, 1'b0, 8'd16); ticks(40);
    input_ok = 1'b0; #1;
    check("R10 no recov without input", recov_en, 0);
    cyc(1); input_ok = 1'b1;
    check("R9 input loss clears", fault, 0);
    arm(1'b1, 1'b0, 8'd16); ticks(40);
    timer_dis = 1'b1; cyc(1); timer_dis = 1'b0;
    check("R9 disable clears", fault, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule